// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block is the controller-side engine that walks a four-bank synchronous DRAM from power-on to a usable state. Once reset is released and the clock is reported stable, it holds the command bus at NOP for a long, parameter-set number of clock cycles. It then closes every bank with a single precharge and issues two auto-refresh commands. Finally it writes the mode register with a word built from configuration inputs and raises a completion flag that a downstream memory controller waits on before it sends any traffic.

Every output is registered and changes only on the rising clock edge. After each command the block holds a separate, parameter-set recovery gap of NOPs: one after the precharge, one after each refresh and one after the mode load. Clock-enable stays high throughout. A synchronous reset restarts the whole sequence from the start of the power-up wait.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted, the outputs are a NOP ({cs_n, ras_n, cas_n, we_n} = 4'b0111) with an all-zero address and bank, clock-enable is high and init_done is low.
- R2: After reset is released, the precharge appears on the outputs just after the PWRUP_CYC-th rising edge counted from the last edge at which clk_stable was sampled low. If no such edge occurred, the count starts at the first edge after reset. Until then the bus carries only NOP.
- R3: The first command is PRECHARGE (4'b0010) with address bit 10 high, all other address bits zero and bank zero.
- R4: Exactly two AUTO REFRESH commands (4'b0001, address and bank zero) follow. The first comes T_RP_CYC cycles after the precharge and the second comes T_RFC_CYC cycles after the first.
- R5: LOAD MODE REGISTER (4'b0000) comes T_RFC_CYC cycles after the second refresh, with bank zero. Its address carries the burst length in bits 2:0, the interleaved-burst flag in bit 3, the CAS latency in bits 6:4, the operating mode in bits 8:7 and the single-write flag in bit 9. All bits from 10 upward are zero.
- R6: init_done rises T_MRD_CYC cycles after the mode load and stays high until reset.
- R7: Each non-NOP command lasts exactly one cycle, and every other cycle of the sequence carries a NOP.
- R8: A synchronous reset asserted mid-sequence or after completion clears init_done and restarts the full sequence from the power-up wait.
- R9: After the mode load, changes on the configuration inputs do not alter the outputs, which stay at NOP with a zero address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_stable | input | 1 | High once the memory clock is stable; low restarts the power-up count |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_burst_interleave | input | 1 | Burst ordering flag for the mode word |
| cfg_cas_lat | input | 3 | CAS latency code for the mode word |
| cfg_op_mode | input | 2 | Operating mode code for the mode word |
| cfg_wr_single | input | 1 | Write burst mode flag for the mode word |
| mem_cke | output | 1 | Clock enable, held high |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ROW_W | Address bus |
| mem_bank | output | BANK_W | Bank select |
| init_done | output | 1 | High once initialization has completed |

## Verification
The in-line assertions check these properties on every cycle:
- a command never lasts longer than one cycle;
- a low clk_stable during the wait keeps the bus at NOP;
- the precharge comes before any refresh;
- init_done only rises once both refreshes have been counted, and then stays high;
- any mode load carries zero guard bits and a zero bank.

Only the bench's scenarios can show the exact cycle distances between commands, the bit placement of every configuration field in the mode word, the restart after a clk_stable drop or a mid-run reset, and that configuration changes after the mode load do nothing.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [3:0] {
      ST_PWRUP,
      ST_PRE,
      ST_TRP,
      ST_REF,
      ST_TRFC,
      ST_LMR,
      ST_TMRD,
      ST_READY
   } init_state_t;

   typedef enum logic [1:0] {
      OP_NOP,
      OP_PRE,
      OP_REF,
      OP_LMR
   } init_op_t;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] PINS_NOP = 4'b0111;
   localparam logic [3:0] PINS_PRE = 4'b0010;
   localparam logic [3:0] PINS_REF = 4'b0001;
   localparam logic [3:0] PINS_LMR = 4'b0000;

   localparam int MODE_W      = 12;
   localparam int PRE_ALL_BIT = 10;
   localparam int REF_NUM     = 2;

   function automatic init_op_t op_of_state(input init_state_t s);
      case (s)
         ST_PRE:  return OP_PRE;
         ST_REF:  return OP_REF;
         ST_LMR:  return OP_LMR;
         default: return OP_NOP;
      endcase
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/init_span_timer.sv
module init_span_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   logic [CNT_W-1:0] count;

   assign expired = (count == limit);

   // saturates at the limit; cleared on phase change
   always_ff @(posedge clk) begin
      if (rst || clr) begin
         count <= '0;
      end else if (inc && !expired) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/init_mode_pack.sv
module init_mode_pack import sdram_init_pkg::*; #(
   parameter int ROW_W = 13
) (
   input  logic [2:0]       burst_len,
   input  logic             burst_interleave,
   input  logic [2:0]       cas_lat,
   input  logic [1:0]       op_mode,
   input  logic             wr_single,
   output logic [ROW_W-1:0] mode_addr
);

   logic [MODE_W-1:0] core;

   // bits 11:10 are guard zeros
   assign core = {2'b00, wr_single, op_mode, cas_lat, burst_interleave, burst_len};

   generate
      if (ROW_W > MODE_W) begin : g_pad
         assign mode_addr = {{(ROW_W-MODE_W){1'b0}}, core};
      end else begin : g_exact
         assign mode_addr = core;
      end
   endgenerate

endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive import sdram_init_pkg::*; #(
   parameter int ROW_W  = 13,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  init_op_t          op,
   input  logic [ROW_W-1:0]  mode_addr,
   output logic [3:0]        pins,
   output logic [ROW_W-1:0]  addr,
   output logic [BANK_W-1:0] bank
);

   localparam logic [ROW_W-1:0] PRE_ADDR = {{(ROW_W-1){1'b0}}, 1'b1} << PRE_ALL_BIT;

   always_ff @(posedge clk) begin
      if (rst) begin
         pins <= PINS_NOP;
         addr <= '0;
         bank <= '0;
      end else begin
         bank <= '0;
         case (op)
            OP_PRE: begin
               pins <= PINS_PRE;
               addr <= PRE_ADDR;
            end
            OP_REF: begin
               pins <= PINS_REF;
               addr <= '0;
            end
            OP_LMR: begin
               pins <= PINS_LMR;
               addr <= mode_addr;
            end
            default: begin
               pins <= PINS_NOP;
               addr <= '0;
            end
         endcase
      end
   end

   // guard bits and bank must be zero on a mode load
   p_mode_guard_r5: assert property (@(posedge clk) disable iff (rst)
      (pins == PINS_LMR) |-> (addr[MODE_W-1:MODE_W-2] == 2'b00 && bank == '0));

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq import sdram_init_pkg::*; #(
   parameter int ROW_W     = 13,
   parameter int BANK_W    = 2,
   parameter int PWRUP_CYC = 13334,
   parameter int T_RP_CYC  = 3,
   parameter int T_RFC_CYC = 10,
   parameter int T_MRD_CYC = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clk_stable,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_burst_interleave,
   input  logic [2:0]        cfg_cas_lat,
   input  logic [1:0]        cfg_op_mode,
   input  logic              cfg_wr_single,
   output logic              mem_cke,
   output logic              mem_cs_n,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [ROW_W-1:0]  mem_addr,
   output logic [BANK_W-1:0] mem_bank,
   output logic              init_done
);

   localparam int SPAN_MAX = max_of(max_of(PWRUP_CYC, T_RP_CYC), max_of(T_RFC_CYC, T_MRD_CYC));
   localparam int CNT_W    = $clog2(SPAN_MAX + 1);
   localparam int TALLY_W  = $clog2(REF_NUM + 1);

   localparam logic [CNT_W-1:0]   LIM_PWRUP = CNT_W'(PWRUP_CYC - 1);
   localparam logic [CNT_W-1:0]   LIM_TRP   = CNT_W'(T_RP_CYC - 2);
   localparam logic [CNT_W-1:0]   LIM_TRFC  = CNT_W'(T_RFC_CYC - 2);
   localparam logic [CNT_W-1:0]   LIM_TMRD  = CNT_W'(T_MRD_CYC - 2);
   localparam logic [TALLY_W-1:0] LIM_REFS  = TALLY_W'(REF_NUM);

   generate
      if (ROW_W < MODE_W) begin : g_bad_row
         $error("ROW_W must hold the full mode word");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("BANK_W must be at least 1");
      end
      if (PWRUP_CYC < 1) begin : g_bad_pwrup
         $error("PWRUP_CYC must be at least 1");
      end
      if (T_RP_CYC < 2 || T_RFC_CYC < 2 || T_MRD_CYC < 2) begin : g_bad_gap
         $error("recovery gaps must be at least 2 cycles");
      end
   endgenerate

   init_state_t      st, st_nx;
   logic [CNT_W-1:0] span_limit;
   logic             span_clr, span_exp;
   logic             tally_clr, tally_inc, tally_exp;
   logic [ROW_W-1:0] mode_addr;
   logic [3:0]       pins;

   // next-state logic
   always_comb begin
      st_nx = st;
      case (st)
         ST_PWRUP: if (clk_stable && span_exp) st_nx = ST_PRE;
         ST_PRE:   st_nx = ST_TRP;
         ST_TRP:   if (span_exp) st_nx = ST_REF;
         ST_REF:   st_nx = ST_TRFC;
         ST_TRFC:  if (span_exp) st_nx = tally_exp ? ST_LMR : ST_REF;
         ST_LMR:   st_nx = ST_TMRD;
         ST_TMRD:  if (span_exp) st_nx = ST_READY;
         ST_READY: st_nx = ST_READY;
         default:  st_nx = ST_PWRUP;
      endcase
   end

   always_comb begin
      case (st)
         ST_PWRUP: span_limit = LIM_PWRUP;
         ST_TRP:   span_limit = LIM_TRP;
         ST_TRFC:  span_limit = LIM_TRFC;
         ST_TMRD:  span_limit = LIM_TMRD;
         default:  span_limit = '0;
      endcase
   end

   assign span_clr  = (st_nx != st) || (st == ST_PWRUP && !clk_stable);
   assign tally_clr = (st == ST_PWRUP);
   assign tally_inc = (st == ST_REF);

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_PWRUP;
         init_done <= 1'b0;
      end else begin
         st <= st_nx;
         if (st_nx == ST_READY) init_done <= 1'b1;
      end
   end

   init_span_timer #(.CNT_W(CNT_W)) span_i (
      .clk     (clk),
      .rst     (rst),
      .clr     (span_clr),
      .inc     (1'b1),
      .limit   (span_limit),
      .expired (span_exp)
   );

   init_span_timer #(.CNT_W(TALLY_W)) tally_i (
      .clk     (clk),
      .rst     (rst),
      .clr     (tally_clr),
      .inc     (tally_inc),
      .limit   (LIM_REFS),
      .expired (tally_exp)
   );

   init_mode_pack #(.ROW_W(ROW_W)) pack_i (
      .burst_len        (cfg_burst_len),
      .burst_interleave (cfg_burst_interleave),
      .cas_lat          (cfg_cas_lat),
      .op_mode          (cfg_op_mode),
      .wr_single        (cfg_wr_single),
      .mode_addr        (mode_addr)
   );

   init_cmd_drive #(.ROW_W(ROW_W), .BANK_W(BANK_W)) drive_i (
      .clk       (clk),
      .rst       (rst),
      .op        (op_of_state(st_nx)),
      .mode_addr (mode_addr),
      .pins      (pins),
      .addr      (mem_addr),
      .bank      (mem_bank)
   );

   assign mem_cke = 1'b1;
   assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = pins;

   p_single_cmd_r7: assert property (@(posedge clk) disable iff (rst)
      (pins != PINS_NOP) |=> (pins == PINS_NOP));

   p_wait_nop_r2: assert property (@(posedge clk) disable iff (rst)
      (st == ST_PWRUP && !clk_stable) |=> (pins == PINS_NOP));

   p_pre_first_r3: assert property (@(posedge clk) disable iff (rst)
      (pins == PINS_PRE) |-> (!tally_exp && !init_done));

   p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   p_done_after_refs_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(init_done) |-> tally_exp);

endmodule

// File: tb/sdram_pwrup_seq_tb_top.sv
module sdram_pwrup_seq_tb_top;

   localparam int ROW_W  = 13;
   localparam int BANK_W = 2;
   localparam int P      = 20;
   localparam int TRP    = 3;
   localparam int TRFC   = 5;
   localparam int TMRD   = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic clk_stable = 1'b0;
   logic [2:0] bl = '0;
   logic       bt = 1'b0;
   logic [2:0] cl = '0;
   logic [1:0] om = '0;
   logic       wb = 1'b0;
   logic cke, cs_n, ras_n, cas_n, we_n, done;
   logic [ROW_W-1:0]  addr;
   logic [BANK_W-1:0] bank;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   sdram_pwrup_seq #(
      .ROW_W(ROW_W), .BANK_W(BANK_W), .PWRUP_CYC(P),
      .T_RP_CYC(TRP), .T_RFC_CYC(TRFC), .T_MRD_CYC(TMRD)
   ) dut_i (
      .clk(clk), .rst(rst), .clk_stable(clk_stable),
      .cfg_burst_len(bl), .cfg_burst_interleave(bt), .cfg_cas_lat(cl),
      .cfg_op_mode(om), .cfg_wr_single(wb),
      .mem_cke(cke), .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n),
      .mem_we_n(we_n), .mem_addr(addr), .mem_bank(bank), .init_done(done)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] cmd();
      return {cs_n, ras_n, cas_n, we_n};
   endfunction

   // glitch_at: edge index with clk_stable low (0 = none); abort_at: stop early
   task automatic run_one(input logic [2:0] b_len, input logic b_ty,
                          input logic [2:0] c_lat, input logic [1:0] o_md,
                          input logic w_b, input int glitch_at, input int abort_at);
      int t_pre, t_r1, t_r2, t_l, t_d;
      logic [31:0] exp_mode;
      logic [3:0]  exp_cmd;
      string tag;
      bl = b_len; bt = b_ty; cl = c_lat; om = o_md; wb = w_b;
      rst = 1'b1;
      clk_stable = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "reset cmd", 32'(cmd()), 32'h7);
      chk("R1", "reset cke", 32'(cke), 32'h1);
      chk("R1", "reset done", 32'(done), 32'h0);
      chk("R1", "reset addr", 32'(addr), 32'h0);
      t_pre = glitch_at + P;
      t_r1  = t_pre + TRP;
      t_r2  = t_r1 + TRFC;
      t_l   = t_r2 + TRFC;
      t_d   = t_l + TMRD;
      exp_mode = (32'(w_b) << 9) | (32'(o_md) << 7) | (32'(c_lat) << 4)
               | (32'(b_ty) << 3) | 32'(b_len);
      rst = 1'b0;
      clk_stable = (glitch_at != 1);
      for (int n = 1; n <= t_d + 3; n++) begin
         @(negedge clk);
         clk_stable = (n + 1 != glitch_at);
         if (abort_at != 0 && n == abort_at) return;
         if (n < t_pre)                   begin exp_cmd = 4'b0111; tag = "R2"; end
         else if (n == t_pre)             begin exp_cmd = 4'b0010; tag = "R3"; end
         else if (n == t_r1 || n == t_r2) begin exp_cmd = 4'b0001; tag = "R4"; end
         else if (n == t_l)               begin exp_cmd = 4'b0000; tag = "R5"; end
         else                             begin exp_cmd = 4'b0111; tag = "R7"; end
         chk(tag, "cmd", 32'(cmd()), 32'(exp_cmd));
         if (n == t_pre) begin
            chk("R3", "pre addr", 32'(addr), 32'h400);
            chk("R3", "pre bank", 32'(bank), 32'h0);
         end
         if (n == t_r1 || n == t_r2) chk("R4", "ref addr", 32'(addr), 32'h0);
         if (n == t_l) begin
            chk("R5", "mode word", 32'(addr), exp_mode);
            chk("R5", "mode bank", 32'(bank), 32'h0);
         end
         chk("R6", "done", 32'(done), 32'(n >= t_d));
         if (n > t_l) begin
            chk("R9", "addr after load", 32'(addr), 32'h0);
            bl = ~b_len; bt = ~b_ty; cl = ~c_lat; om = ~o_md; wb = ~w_b;
         end
         chk("R1", "cke", 32'(cke), 32'h1);
      end
   endtask

   initial begin
      // near-exhaustive sweep over mode fields
      for (int ib = 0; ib < 8; ib++) begin
         for (int it = 0; it < 2; it++) begin
            for (int ic = 0; ic < 8; ic++) begin
               run_one(3'(ib), 1'(it), 3'(ic), 2'((ib + ic) % 4),
                       1'(it ^ (ic % 2)), 0, 0);
            end
         end
      end
      // R2: clk_stable drops early, mid-wait and on the last wait edge
      run_one(3'd2, 1'b0, 3'd3, 2'd0, 1'b0, 1, 0);
      run_one(3'd1, 1'b1, 3'd2, 2'd1, 1'b1, 7, 0);
      run_one(3'd3, 1'b0, 3'd2, 2'd2, 1'b0, P, 0);
      // R8: reset between the refreshes, then a full rerun
      run_one(3'd5, 1'b1, 3'd6, 2'd3, 1'b1, 0, P + TRP + 2);
      rst = 1'b1;
      @(negedge clk);
      chk("R8", "cmd after mid reset", 32'(cmd()), 32'h7);
      chk("R8", "done after mid reset", 32'(done), 32'h0);
      run_one(3'd5, 1'b1, 3'd6, 2'd3, 1'b1, 0, 0);
      // R8: reset after completion
      rst = 1'b1;
      @(negedge clk);
      chk("R8", "done cleared after finish", 32'(done), 32'h0);
      run_one(3'd7, 1'b0, 3'd1, 2'd2, 1'b0, 0, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule